// File: doc/BRIEF.md
# Register File with Shadow Bank Exchange

This block holds the pair registers of an 8-bit-style datapath. The main set has four pairs: the accumulator/flag pair (flags in the low byte), and three general pairs, here called BC, DE and HL. Each of these four has a shadow copy. Two 16-bit index registers, IX and IY, have no shadow. The surrounding core reads any main pair through a combinational read port and writes a whole pair, or one byte of it, through a write port with byte enables.

The block also runs the exchange commands. One command swaps BC, DE and HL with their shadow copies at the same clock edge. Another swaps the accumulator/flag pair with its shadow, flags included. A third swaps DE with HL. The stack-top command swaps HL, IX or IY with a word taken from the top of the stack. For this command the block only shows the old value of the chosen register on a port and loads the incoming word on the strobe edge. Reading and writing memory is left to the core. The shadow set is reached only through the exchange commands, so ordinary reads and writes see only the main set.

Top module: `regbank_xchg`

## Requirements
- R1: After the asynchronous active-low reset, every main and every shadow register reads zero.
- R2: `rd_data_o` shows, in the same cycle, the main pair picked by `rd_sel_i`: 0 AF, 1 BC, 2 DE, 3 HL, 4 IX, 5 IY. Codes 6 and 7 read zero.
- R3: A write with `wr_en_i` high updates the selected main pair at the next rising edge. `wr_be_i[0]` enables the low byte and `wr_be_i[1]` the high byte. Codes 6 and 7 change nothing.
- R4: Ordinary writes never change a shadow register. Shadow registers change only under exchange codes 1 and 2.
- R5: `xchg_i` = 1 swaps BC, DE and HL with their shadows in one clock. AF, IX and IY are left unchanged.
- R6: `xchg_i` = 2 swaps AF with its shadow, including the flag byte (the low byte of AF). No other register changes.
- R7: `xchg_i` = 3 swaps DE and HL in one clock. No shadow register changes.
- R8: `stk_sel_i` picks the stack-top target: 0 HL, 1 IX, 2 IY. `stk_old_o` shows that register's current value at all times. With `xchg_i` = 4 the target loads `stk_word_i` at the edge. `stk_sel_i` = 3 makes `stk_old_o` zero, and the command then changes nothing.
- R9: A write to a register that the exchange in the same cycle involves is dropped. A write to any register the exchange does not involve takes effect as usual.
- R10: `xchg_i` = 0 and codes 5 to 7 perform no exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_sel_i | input | 3 | Read pair select |
| rd_data_o | output | 16 | Selected main pair value |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Write pair select |
| wr_be_i | input | 2 | Write byte enables (bit 1 high byte) |
| wr_data_i | input | 16 | Write data |
| xchg_i | input | 3 | Exchange command code |
| stk_sel_i | input | 2 | Stack-top exchange target |
| stk_word_i | input | 16 | Word read from the stack top |
| stk_old_o | output | 16 | Current value of the stack-top target |

## Verification
The hardest case to reach from the ports is a write and an exchange that hit the same register in the same cycle. The bench also has to show that shadow contents survive ordinary traffic, and the shadows can be seen only by swapping them into the main set. Directed sequences first load distinct values, then swap them in and read back every pair. After that they issue each exchange code together with a write aimed at an involved register and at an uninvolved one. A long random phase then mixes all codes, selects and byte enables against a behavioural model that is checked on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned STK_W      = 2;
  localparam int unsigned SRC_W      = 3;
  localparam int unsigned NUM_MAIN   = 6;
  localparam int unsigned NUM_SHADOW = 4;

  localparam int IDX_AF = 0;
  localparam int IDX_BC = 1;
  localparam int IDX_DE = 2;
  localparam int IDX_HL = 3;
  localparam int IDX_IX = 4;
  localparam int IDX_IY = 5;

  localparam logic [STK_W-1:0] STK_NONE = 2'd3;

  typedef enum logic [2:0] {
    XC_NONE = 3'd0,
    XC_ALL  = 3'd1,
    XC_AF   = 3'd2,
    XC_DEHL = 3'd3,
    XC_STK  = 3'd4
  } xchg_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_HOLD   = 3'd0,
    SRC_WR     = 3'd1,
    SRC_SHADOW = 3'd2,
    SRC_PEER   = 3'd3,
    SRC_STACK  = 3'd4
  } src_e;

  // map stack-top target code to main pair index; invalid -> unused code
  function automatic logic [SEL_W-1:0] stk_target(input logic [STK_W-1:0] s);
    case (s)
      2'd0:    return SEL_W'(IDX_HL);
      2'd1:    return SEL_W'(IDX_IX);
      2'd2:    return SEL_W'(IDX_IY);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/regbank_pair.sv
module regbank_pair
  import regbank_pkg::*;
#(
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned BE_W   = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BE_W-1:0]   we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [BE_W-1:0][BYTE_W-1:0] lane_q;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q[b] <= '0;
      else if (we_i[b])   lane_q[b] <= d_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign q_o = lane_q;
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N      = NUM_MAIN
) (
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [N-1:0][DATA_W-1:0] bank_i,
  output logic [DATA_W-1:0]        data_o
);
  // codes beyond the bank read zero
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) data_o = bank_i[k];
    end
  end
endmodule

// File: rtl/regbank_ctl.sv
module regbank_ctl
  import regbank_pkg::*;
#(
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned BE_W   = DATA_W / BYTE_W
) (
  input  logic [2:0]                         xchg_i,
  input  logic                               wr_en_i,
  input  logic [SEL_W-1:0]                   wr_sel_i,
  input  logic [BE_W-1:0]                    wr_be_i,
  input  logic [STK_W-1:0]                   stk_sel_i,
  output logic [NUM_MAIN-1:0][SRC_W-1:0]     src_o,
  output logic [NUM_MAIN-1:0][BE_W-1:0]      we_o,
  output logic [NUM_SHADOW-1:0]              shd_ld_o
);
  logic [NUM_MAIN-1:0] xinv;
  logic [SEL_W-1:0]    stk_idx;

  assign stk_idx = stk_target(stk_sel_i);

  // registers claimed by the current exchange
  always_comb begin
    xinv = '0;
    case (xchg_i)
      XC_ALL: begin
        xinv[IDX_BC] = 1'b1;
        xinv[IDX_DE] = 1'b1;
        xinv[IDX_HL] = 1'b1;
      end
      XC_AF:   xinv[IDX_AF] = 1'b1;
      XC_DEHL: begin
        xinv[IDX_DE] = 1'b1;
        xinv[IDX_HL] = 1'b1;
      end
      XC_STK: begin
        for (int k = 0; k < NUM_MAIN; k++)
          if (stk_sel_i != STK_NONE && stk_idx == SEL_W'(k)) xinv[k] = 1'b1;
      end
      default: ;
    endcase
  end

  // exchange wins over an ordinary write on the same register
  always_comb begin
    for (int k = 0; k < NUM_MAIN; k++) begin
      src_o[k] = SRC_HOLD;
      we_o[k]  = '0;
      if (xinv[k]) begin
        we_o[k] = '1;
        case (xchg_i)
          XC_ALL, XC_AF: src_o[k] = SRC_SHADOW;
          XC_DEHL:       src_o[k] = SRC_PEER;
          default:       src_o[k] = SRC_STACK;
        endcase
      end else if (wr_en_i && wr_sel_i == SEL_W'(k)) begin
        src_o[k] = SRC_WR;
        we_o[k]  = wr_be_i;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_SHADOW; k++) begin
      shd_ld_o[k] = (xchg_i == XC_AF  && k == IDX_AF) ||
                    (xchg_i == XC_ALL && k != IDX_AF);
    end
  end
endmodule

// File: rtl/regbank_xchg.sv
module regbank_xchg
  import regbank_pkg::*;
#(
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned BE_W   = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        xchg_i,
  input  logic [STK_W-1:0]  stk_sel_i,
  input  logic [DATA_W-1:0] stk_word_i,
  output logic [DATA_W-1:0] stk_old_o
);
  logic [NUM_MAIN-1:0][DATA_W-1:0]   main_q;
  logic [NUM_SHADOW-1:0][DATA_W-1:0] shd_q;
  logic [NUM_MAIN-1:0][SRC_W-1:0]    src;
  logic [NUM_MAIN-1:0][BE_W-1:0]     we;
  logic [NUM_SHADOW-1:0]             shd_ld;

  regbank_ctl #(.DATA_W(DATA_W)) u_ctl (
    .xchg_i   (xchg_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_be_i  (wr_be_i),
    .stk_sel_i(stk_sel_i),
    .src_o    (src),
    .we_o     (we),
    .shd_ld_o (shd_ld)
  );

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
    localparam int PEER = (i == IDX_DE) ? IDX_HL : (i == IDX_HL) ? IDX_DE : i;
    localparam int SH   = (i < NUM_SHADOW) ? i : 0;
    logic [DATA_W-1:0] d;

    always_comb begin
      case (src[i])
        SRC_WR:     d = wr_data_i;
        SRC_SHADOW: d = shd_q[SH];
        SRC_PEER:   d = main_q[PEER];
        SRC_STACK:  d = stk_word_i;
        default:    d = main_q[i];
      endcase
    end

    regbank_pair #(.DATA_W(DATA_W)) u_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (we[i]),
      .d_i   (d),
      .q_o   (main_q[i])
    );
  end

  for (genvar j = 0; j < NUM_SHADOW; j++) begin : g_shd
    regbank_pair #(.DATA_W(DATA_W)) u_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  ({BE_W{shd_ld[j]}}),
      .d_i   (main_q[j]),
      .q_o   (shd_q[j])
    );
  end

  regbank_rdmux #(.DATA_W(DATA_W), .N(NUM_MAIN)) u_rd (
    .sel_i (rd_sel_i),
    .bank_i(main_q),
    .data_o(rd_data_o)
  );

  regbank_rdmux #(.DATA_W(DATA_W), .N(NUM_MAIN)) u_stk (
    .sel_i (stk_target(stk_sel_i)),
    .bank_i(main_q),
    .data_o(stk_old_o)
  );

  assert_shadow_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xchg_i == XC_ALL || xchg_i == XC_AF) |=> $stable(shd_q));

  assert_full_swap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i == XC_ALL |=>
      main_q[IDX_BC] == $past(shd_q[IDX_BC]) && shd_q[IDX_BC] == $past(main_q[IDX_BC]) &&
      main_q[IDX_DE] == $past(shd_q[IDX_DE]) && shd_q[IDX_DE] == $past(main_q[IDX_DE]) &&
      main_q[IDX_HL] == $past(shd_q[IDX_HL]) && shd_q[IDX_HL] == $past(main_q[IDX_HL]));

  assert_af_swap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i == XC_AF |=>
      main_q[IDX_AF] == $past(shd_q[IDX_AF]) && shd_q[IDX_AF] == $past(main_q[IDX_AF]));

  assert_dehl_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i == XC_DEHL |=>
      main_q[IDX_DE] == $past(main_q[IDX_HL]) && main_q[IDX_HL] == $past(main_q[IDX_DE]));

  assert_stk_hl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i == XC_STK && stk_sel_i == 2'd0 |=> main_q[IDX_HL] == $past(stk_word_i));

  assert_stk_iy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i == XC_STK && stk_sel_i == 2'd2 |=> main_q[IDX_IY] == $past(stk_word_i));

  assert_no_xchg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i > 3'd4 && !wr_en_i |=> $stable(main_q) && $stable(shd_q));
endmodule

// File: tb/regbank_xchg_tb.sv
`timescale 1ns/1ps
module regbank_xchg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  xchg = '0;
  logic [1:0]  stk_sel = '0;
  logic [15:0] stk_word = '0;
  logic [15:0] stk_old;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur = "R1";

  logic [15:0] m [6];
  logic [15:0] s [4];

  always #2 clk = ~clk;

  regbank_xchg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_be_i(wr_be), .wr_data_i(wr_data),
    .xchg_i(xchg), .stk_sel_i(stk_sel), .stk_word_i(stk_word), .stk_old_o(stk_old)
  );

  function automatic logic [15:0] exp_rd(input logic [2:0] sel);
    return (sel < 3'd6) ? m[sel] : 16'h0;
  endfunction

  function automatic int tgt(input logic [1:0] ss);
    case (ss)
      2'd0: return 3;
      2'd1: return 4;
      2'd2: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic bit involved(input int r);
    case (xchg)
      3'd1: return (r >= 1 && r <= 3);
      3'd2: return (r == 0);
      3'd3: return (r == 2 || r == 3);
      3'd4: return (r == tgt(stk_sel));
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [15:0] nm [6];
    logic [15:0] ns [4];
    int t;
    for (int k = 0; k < 6; k++) nm[k] = m[k];
    for (int k = 0; k < 4; k++) ns[k] = s[k];
    case (xchg)
      3'd1: for (int k = 1; k < 4; k++) begin nm[k] = s[k]; ns[k] = m[k]; end
      3'd2: begin nm[0] = s[0]; ns[0] = m[0]; end
      3'd3: begin nm[2] = m[3]; nm[3] = m[2]; end
      3'd4: begin t = tgt(stk_sel); if (t >= 0) nm[t] = stk_word; end
      default: ;
    endcase
    if (wr_en && wr_sel < 3'd6 && !involved(int'(wr_sel))) begin
      if (wr_be[0]) nm[wr_sel][7:0]  = wr_data[7:0];
      if (wr_be[1]) nm[wr_sel][15:8] = wr_data[15:8];
    end
    for (int k = 0; k < 6; k++) m[k] = nm[k];
    for (int k = 0; k < 4; k++) s[k] = ns[k];
  endtask

  // called at a falling edge with inputs already driven
  task automatic step();
    int t;
    #1;
    chk({cur, " rd"}, rd_data, exp_rd(rd_sel));
    t = tgt(stk_sel);
    chk({cur, " stk_old R8"}, stk_old, (t >= 0) ? m[t] : 16'h0);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; xchg = 3'd0; wr_be = 2'b00;
  endtask

  task automatic dump();
    idle();
    for (int k = 0; k < 8; k++) begin
      rd_sel = 3'(k);
      step();
    end
  endtask

  task automatic wr(input int sel, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_be = be; wr_data = d;
  endtask

  task automatic cmd(input logic [2:0] c, input logic [1:0] ss, input logic [15:0] w);
    xchg = c; stk_sel = ss; stk_word = w;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) m[k] = '0;
    for (int k = 0; k < 4; k++) s[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held
    cur = "R1";
    for (int k = 0; k < 8; k++) begin
      rd_sel = 3'(k); #0.2;
      chk("R1 in reset", rd_data, 16'h0);
    end
    rst_n = 1'b1;
    dump();
    cmd(3'd1, 2'd0, 16'h0); step();
    cmd(3'd2, 2'd0, 16'h0); step();
    dump();  // R1: shadows were zero
    idle(); cmd(3'd1, 2'd0, 16'h0); step();
    cmd(3'd2, 2'd0, 16'h0); step();

    // R3: full and byte writes
    cur = "R3";
    for (int k = 0; k < 6; k++) begin
      idle(); wr(k, 2'b11, 16'h1357 + 16'(k) * 16'h2111); step();
    end
    dump();
    idle(); wr(1, 2'b01, 16'hAAC3); step();
    idle(); wr(2, 2'b10, 16'h5Cff); step();
    idle(); wr(3, 2'b00, 16'hFFFF); step();
    idle(); wr(6, 2'b11, 16'hDEAD); step();
    idle(); wr(7, 2'b11, 16'hBEEF); step();
    dump();

    // R5: full bank swap, then R4: writes do not reach shadows
    cur = "R5";
    idle(); cmd(3'd1, 2'd0, 16'h0); step();
    dump();
    cur = "R4";
    for (int k = 0; k < 4; k++) begin
      idle(); wr(k, 2'b11, 16'hC000 | 16'(k)); step();
    end
    idle(); cmd(3'd1, 2'd0, 16'h0); step();
    idle(); cmd(3'd2, 2'd0, 16'h0); step();
    dump();

    // R6: accumulator/flag pair swap
    cur = "R6";
    idle(); wr(0, 2'b11, 16'h7F81); step();
    idle(); cmd(3'd2, 2'd0, 16'h0); step();
    dump();
    idle(); cmd(3'd2, 2'd0, 16'h0); step();
    dump();

    // R7: DE <-> HL
    cur = "R7";
    idle(); cmd(3'd3, 2'd0, 16'h0); step();
    dump();

    // R8: stack-top exchange for each target code
    cur = "R8";
    for (int k = 0; k < 4; k++) begin
      idle(); cmd(3'd4, 2'(k), 16'h9A00 | 16'(k)); rd_sel = 3'd3; step();
      idle(); step();
    end
    dump();

    // R9: exchange and write on the same cycle
    cur = "R9";
    idle(); cmd(3'd3, 2'd0, 16'h0); wr(2, 2'b11, 16'h1111); step();
    idle(); cmd(3'd1, 2'd0, 16'h0); wr(1, 2'b11, 16'h2222); step();
    idle(); cmd(3'd1, 2'd0, 16'h0); wr(4, 2'b11, 16'h3333); step();
    idle(); cmd(3'd4, 2'd1, 16'h4444); wr(4, 2'b11, 16'h5555); step();
    idle(); cmd(3'd4, 2'd1, 16'h6666); wr(3, 2'b11, 16'h7777); step();
    idle(); cmd(3'd2, 2'd0, 16'h0); wr(0, 2'b11, 16'h8888); step();
    idle(); cmd(3'd2, 2'd0, 16'h0); wr(5, 2'b10, 16'h99AA); step();
    dump();

    // R10: unused exchange codes
    cur = "R10";
    for (int c = 5; c < 8; c++) begin
      idle(); cmd(3'(c), 2'd0, 16'hFFFF); step();
      idle(); cmd(3'(c), 2'd1, 16'h0F0F); wr(0, 2'b11, 16'h0C00 | 16'(c)); step();
    end
    dump();

    // R2: random mix against the model
    cur = "R2";
    for (int n = 0; n < 3000; n++) begin
      rd_sel   = 3'($urandom_range(0, 7));
      wr_en    = 1'($urandom_range(0, 1));
      wr_sel   = 3'($urandom_range(0, 7));
      wr_be    = 2'($urandom_range(0, 3));
      wr_data  = 16'($urandom);
      xchg     = 3'($urandom_range(0, 7));
      stk_sel  = 2'($urandom_range(0, 3));
      stk_word = 16'($urandom);
      step();
    end
    dump();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule